// File: doc/BRIEF.md
# Bank-Aware Prefetch Issue Arbiter

This block sits between a core's prefetch generator and its miss-tracking registers and picks which queued prefetch is sent next. Incoming prefetches carry a DRAM bank index and are parked in a small first-in first-out queue for that bank. For every bank the block also counts how many requests to that bank are currently outstanding in the miss registers, following allocate and free events reported by those registers.

Each time the output stage can take a new request, the block considers only the front entry of each bank queue. A front entry may go out only when its bank's outstanding count is at or below a send threshold. Among those, the one whose bank is least busy wins, with the lowest bank index breaking ties. The threshold follows prefetch accuracy: the block counts useful and issued prefetches over a fixed sampling interval, turns the ratio into a coarse level at each interval end, and maps that level onto a small, middle or large threshold. Nothing is issued while the miss registers are all in use.

Top module: `pf_bank_issue_arb`

## Requirements
- R1: Each bank has its own queue of FIFO_DEPTH entries; prefetches to one bank leave in arrival order, and `pf_ready` is low exactly when the queue selected by `pf_bank` is full.
- R2: A bank's outstanding count rises by one on its `alloc_vec` bit and falls by one on its `free_vec` bit, stays unchanged when both are set in the same cycle, never drops below 0 and never rises above MSHR_ENTRIES.
- R3: A queue front is eligible only when its bank's outstanding count is less than or equal to the current send threshold.
- R4: Among eligible fronts the bank with the smallest outstanding count is issued; equal counts go to the lowest bank index.
- R5: The threshold is THR_LOW (1) at accuracy below 40%, THR_MID (7) from 40% up to below 85%, and THR_HIGH (27) at 85% and above; both boundaries are inclusive on the upper side, and after reset the low level applies.
- R6: Accuracy is useful over issued prefetch pulses counted over SAMPLE_PERIOD cycles; the level changes only at the end of an interval, both counts clear there, and an interval with no issued pulse keeps the previous level.
- R7: No prefetch is loaded into the output while the sum of all outstanding counts is at least MSHR_ENTRIES.
- R8: The output is registered; while `out_valid` is high and `out_ready` is low, `out_valid`, `out_bank` and `out_addr` hold, and a new prefetch is loaded in the same cycle the held one is accepted.
- R9: After reset `out_valid` is low, every queue is empty (`pf_ready` high) and all outstanding counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_valid | input | 1 | New prefetch offered |
| pf_bank | input | BANK_W | Bank index of the offered prefetch |
| pf_addr | input | ADDR_W | Address of the offered prefetch |
| pf_ready | output | 1 | Queue of `pf_bank` has room |
| alloc_vec | input | NUM_BANKS | One bit per bank: a miss entry was allocated this cycle |
| free_vec | input | NUM_BANKS | One bit per bank: a miss entry was freed this cycle |
| useful_pulse | input | 1 | One useful prefetch observed this cycle |
| issued_pulse | input | 1 | One issued prefetch counted this cycle |
| out_valid | output | 1 | Issued prefetch available |
| out_bank | output | BANK_W | Bank of the issued prefetch |
| out_addr | output | ADDR_W | Address of the issued prefetch |
| out_ready | input | 1 | Consumer takes the issued prefetch |

## Verification
On every cycle the assertions check that outstanding counts step and saturate correctly, that queues are never pushed when full or popped when empty, that a held output stays stable, that nothing is loaded while the miss registers are full, that a loaded bank was within threshold, and that the accuracy level moves only at interval ends. Which bank wins among several eligible ones, the tie rule, the exact threshold boundaries at 40% and 85%, counter clearing between intervals and per-bank ordering are only shown by the bench scenarios, which set up occupancies and accuracy and then observe the single issued prefetch.

// File: rtl/pf_issue_pkg.sv
package pf_issue_pkg;
  typedef enum logic [1:0] {
    ACC_LOW  = 2'd0,
    ACC_MID  = 2'd1,
    ACC_HIGH = 2'd2
  } acc_level_e;
endpackage

// File: rtl/pf_bank_fifo.sv
module pf_bank_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);

  // R1
  push_full_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R1
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/bank_occ_ctr.sv
module bank_occ_ctr #(
  parameter int MAXV = 32,
  parameter int W    = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] occ
);
  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (occ != W'(MAXV)) occ <= occ + W'(1);
        2'b01:   if (occ != '0)       occ <= occ - W'(1);
        default: occ <= occ;
      endcase
    end
  end

  // R2
  occ_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && occ < W'(MAXV)) |=> occ == $past(occ) + W'(1));
  // R2
  occ_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> $stable(occ));
  // R2
  occ_cap_chk: assert property (@(posedge clk) disable iff (rst) occ <= W'(MAXV));
endmodule

// File: rtl/pf_accuracy_tracker.sv
module pf_accuracy_tracker
  import pf_issue_pkg::*;
#(
  parameter int PERIOD   = 100000,
  parameter int PCT_MID  = 40,
  parameter int PCT_HIGH = 85
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       useful,
  input  logic       issued,
  output acc_level_e level
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int CW = $clog2(PERIOD + 1);
  localparam int MW = CW + 7;

  logic [PW-1:0] per_cnt;
  logic [CW-1:0] u_cnt, i_cnt, u_nx, i_nx;
  logic [MW-1:0] u_sc, i_mid, i_high;
  logic          tick;

  assign tick   = (per_cnt == PW'(PERIOD - 1));
  assign u_nx   = u_cnt + CW'(useful);
  assign i_nx   = i_cnt + CW'(issued);
  assign u_sc   = MW'(u_nx) * MW'(100);
  assign i_mid  = MW'(i_nx) * MW'(PCT_MID);
  assign i_high = MW'(i_nx) * MW'(PCT_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt <= '0;
      u_cnt   <= '0;
      i_cnt   <= '0;
      level   <= ACC_LOW;
    end else begin
      per_cnt <= tick ? '0 : per_cnt + PW'(1);
      if (tick) begin
        u_cnt <= '0;
        i_cnt <= '0;
        if (i_nx != '0) begin
          if (u_sc >= i_high)     level <= ACC_HIGH;
          else if (u_sc >= i_mid) level <= ACC_MID;
          else                    level <= ACC_LOW;
        end
      end else begin
        u_cnt <= u_nx;
        i_cnt <= i_nx;
      end
    end
  end

  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(level));
endmodule

// File: rtl/min_occ_picker.sv
module min_occ_picker #(
  parameter int NB = 4,
  parameter int OW = 6,
  parameter int BW = 2
) (
  input  logic [OW-1:0] occ [NB],
  input  logic [NB-1:0] has_head,
  input  logic [OW-1:0] thr,
  output logic          found,
  output logic [BW-1:0] idx
);
  logic [OW-1:0] best;

  // strict less-than keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int b = 0; b < NB; b++) begin
      if (has_head[b] && (occ[b] <= thr) && (!found || (occ[b] < best))) begin
        found = 1'b1;
        idx   = BW'(b);
        best  = occ[b];
      end
    end
  end
endmodule

// File: rtl/pf_bank_issue_arb.sv
module pf_bank_issue_arb
  import pf_issue_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int FIFO_DEPTH    = 4,
  parameter int ADDR_W        = 32,
  parameter int MSHR_ENTRIES  = 32,
  parameter int SAMPLE_PERIOD = 100000,
  parameter int THR_LOW       = 1,
  parameter int THR_MID       = 7,
  parameter int THR_HIGH      = 27,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pf_valid,
  input  logic [BANK_W-1:0]    pf_bank,
  input  logic [ADDR_W-1:0]    pf_addr,
  output logic                 pf_ready,
  input  logic [NUM_BANKS-1:0] alloc_vec,
  input  logic [NUM_BANKS-1:0] free_vec,
  input  logic                 useful_pulse,
  input  logic                 issued_pulse,
  output logic                 out_valid,
  output logic [BANK_W-1:0]    out_bank,
  output logic [ADDR_W-1:0]    out_addr,
  input  logic                 out_ready
);
  localparam int OW = $clog2(MSHR_ENTRIES + 1);
  localparam int SW = OW + BANK_W + 1;

  logic [ADDR_W-1:0]    head [NUM_BANKS];
  logic [OW-1:0]        occ  [NUM_BANKS];
  logic [NUM_BANKS-1:0] full_vec, empty_vec, push_vec, pop_vec;
  logic [SW-1:0]        occ_total;
  logic [OW-1:0]        thr;
  acc_level_e           level;
  logic                 found, load_en, mshr_full;
  logic [BANK_W-1:0]    pick_idx;

  // per-bank queue and outstanding counter
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign push_vec[b] = pf_valid && pf_ready && (pf_bank == BANK_W'(b));
    assign pop_vec[b]  = load_en && (pick_idx == BANK_W'(b));

    pf_bank_fifo #(.DEPTH(FIFO_DEPTH), .DW(ADDR_W)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (push_vec[b]),
      .din   (pf_addr),
      .pop   (pop_vec[b]),
      .dout  (head[b]),
      .full  (full_vec[b]),
      .empty (empty_vec[b])
    );

    bank_occ_ctr #(.MAXV(MSHR_ENTRIES), .W(OW)) u_occ (
      .clk (clk),
      .rst (rst),
      .inc (alloc_vec[b]),
      .dec (free_vec[b]),
      .occ (occ[b])
    );
  end

  always_comb begin
    pf_ready = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (pf_bank == BANK_W'(b)) pf_ready = !full_vec[b];
    end
  end

  always_comb begin
    occ_total = '0;
    for (int b = 0; b < NUM_BANKS; b++) occ_total = occ_total + SW'(occ[b]);
  end
  assign mshr_full = (occ_total >= SW'(MSHR_ENTRIES));

  pf_accuracy_tracker #(.PERIOD(SAMPLE_PERIOD), .PCT_MID(40), .PCT_HIGH(85)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .useful (useful_pulse),
    .issued (issued_pulse),
    .level  (level)
  );

  always_comb begin
    case (level)
      ACC_HIGH: thr = OW'(THR_HIGH);
      ACC_MID:  thr = OW'(THR_MID);
      default:  thr = OW'(THR_LOW);
    endcase
  end

  min_occ_picker #(.NB(NUM_BANKS), .OW(OW), .BW(BANK_W)) u_pick (
    .occ      (occ),
    .has_head (~empty_vec),
    .thr      (thr),
    .found    (found),
    .idx      (pick_idx)
  );

  assign load_en = (!out_valid || out_ready) && found && !mshr_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bank  <= '0;
      out_addr  <= '0;
    end else if (load_en) begin
      out_valid <= 1'b1;
      out_bank  <= pick_idx;
      out_addr  <= head[pick_idx];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bank) && $stable(out_addr)));
  // R7
  mshr_full_chk: assert property (@(posedge clk) disable iff (rst)
    (mshr_full && !out_valid) |=> !out_valid);
  // R3
  pick_thr_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |-> (occ[pick_idx] <= thr));
endmodule

// File: tb/tb_pf_bank_issue_arb.sv
module tb_pf_bank_issue_arb;
  localparam int NB = 4;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int PERIOD = 64;
  localparam logic [AW-1:0] DUMMY = 32'hDEAD_0000;

  logic          clk = 1'b0;
  logic          rst;
  logic          pf_valid;
  logic [1:0]    pf_bank;
  logic [AW-1:0] pf_addr;
  logic          pf_ready;
  logic [NB-1:0] alloc_vec, free_vec;
  logic          useful_pulse, issued_pulse;
  logic          out_valid;
  logic [1:0]    out_bank;
  logic [AW-1:0] out_addr;
  logic          out_ready;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  pf_bank_issue_arb #(
    .NUM_BANKS(NB), .FIFO_DEPTH(DEPTH), .ADDR_W(AW), .MSHR_ENTRIES(32),
    .SAMPLE_PERIOD(PERIOD), .THR_LOW(1), .THR_MID(7), .THR_HIGH(27)
  ) dut (
    .clk(clk), .rst(rst), .pf_valid(pf_valid), .pf_bank(pf_bank), .pf_addr(pf_addr),
    .pf_ready(pf_ready), .alloc_vec(alloc_vec), .free_vec(free_vec),
    .useful_pulse(useful_pulse), .issued_pulse(issued_pulse),
    .out_valid(out_valid), .out_bank(out_bank), .out_addr(out_addr), .out_ready(out_ready)
  );

  // useful count out of 20 issued, target occupancies {b3,b2,b1,b0},
  // banks given a prefetch, expected valid and bank
  typedef struct packed {
    logic [4:0]      useful;
    logic [3:0][5:0] occ;
    logic [3:0]      mask;
    logic            ev;
    logic [1:0]      eb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  {6'd0, 6'd0, 6'd0, 6'd0},  4'b1111, 1'b1, 2'd0}, // R4 tie, low index
    '{5'd0,  {6'd1, 6'd0, 6'd1, 6'd2},  4'b1111, 1'b1, 2'd2}, // R4 minimum
    '{5'd0,  {6'd4, 6'd5, 6'd3, 6'd2},  4'b1111, 1'b0, 2'd0}, // R3 none within 1
    '{5'd0,  {6'd4, 6'd3, 6'd2, 6'd1},  4'b1111, 1'b1, 2'd0}, // R3 equal to threshold
    '{5'd8,  {6'd9, 6'd7, 6'd7, 6'd8},  4'b1111, 1'b1, 2'd1}, // R5 40% -> 7, tie
    '{5'd7,  {6'd6, 6'd2, 6'd3, 6'd5},  4'b1111, 1'b0, 2'd0}, // R5 35% -> 1
    '{5'd8,  {6'd6, 6'd2, 6'd3, 6'd5},  4'b1111, 1'b1, 2'd2}, // R5 40% -> 7
    '{5'd17, {6'd0, 6'd0, 6'd0, 6'd27}, 4'b0001, 1'b1, 2'd0}, // R5 85% -> 27
    '{5'd16, {6'd0, 6'd0, 6'd0, 6'd27}, 4'b0001, 1'b0, 2'd0}, // R5 80% -> 7
    '{5'd17, {6'd0, 6'd0, 6'd5, 6'd27}, 4'b0101, 1'b0, 2'd0}, // R7 total 32
    '{5'd17, {6'd0, 6'd0, 6'd5, 6'd26}, 4'b0101, 1'b1, 2'd2}, // R7 total 31
    '{5'd0,  {6'd0, 6'd1, 6'd1, 6'd0},  4'b0110, 1'b1, 2'd1}, // R4 empty queues skipped
    '{5'd20, {6'd20, 6'd0, 6'd0, 6'd0}, 4'b1000, 1'b1, 2'd3}  // R5 100% -> 27
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    pf_valid = 1'b0; pf_bank = '0; pf_addr = '0;
    alloc_vec = '0; free_vec = '0;
    useful_pulse = 1'b0; issued_pulse = 1'b0; out_ready = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) step(1);
  endtask

  task automatic set_level(input int u);
    for (int i = 0; i < 20; i++) begin
      issued_pulse = 1'b1;
      useful_pulse = (i < u);
      step(1);
    end
    issued_pulse = 1'b0;
    useful_pulse = 1'b0;
  endtask

  task automatic push(input logic [1:0] b, input logic [AW-1:0] a);
    pf_valid = 1'b1; pf_bank = b; pf_addr = a;
    step(1);
    pf_valid = 1'b0;
  endtask

  task automatic set_occ(input logic [3:0][5:0] o);
    for (int k = 0; k < 32; k++) begin
      for (int b = 0; b < NB; b++) alloc_vec[b] = (6'(k) < o[b]);
      step(1);
    end
    alloc_vec = '0;
  endtask

  task automatic bump(input int b, input bit a, input bit f, input int n);
    for (int k = 0; k < n; k++) begin
      alloc_vec[b] = a; free_vec[b] = f;
      step(1);
    end
    alloc_vec = '0; free_vec = '0;
  endtask

  task automatic pulse_ready();
    out_ready = 1'b1;
    step(1);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] ea;
    // R9 reset state
    apply_reset();
    step(1);
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    chk(pf_ready == 1'b1, "R9 pf_ready", pf_ready, 1);

    // table of scenarios: R3 R4 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      apply_reset();
      set_level(VECS[i].useful);
      wait_until(70);
      push(2'd3, DUMMY);
      step(3);
      chk(out_valid && out_addr == DUMMY, "R8 first load", out_addr, DUMMY);
      set_occ(VECS[i].occ);
      for (int b = 0; b < NB; b++)
        if (VECS[i].mask[b]) push(2'(b), 32'hC000_0000 | AW'(i << 4) | AW'(b));
      step(2);
      chk(out_valid && out_addr == DUMMY, "R8 hold", out_addr, DUMMY);
      pulse_ready();
      chk(out_valid == VECS[i].ev, "R3/R4/R5/R7 valid", out_valid, VECS[i].ev);
      if (VECS[i].ev) begin
        ea = 32'hC000_0000 | AW'(i << 4) | AW'(VECS[i].eb);
        chk(out_bank == VECS[i].eb, "R4 bank", out_bank, VECS[i].eb);
        chk(out_addr == ea, "R4 addr", out_addr, ea);
      end
    end

    // R1 ordering within one bank
    apply_reset();
    push(2'd1, 32'h0000_00A1);
    push(2'd1, 32'h0000_00B2);
    push(2'd1, 32'h0000_00C3);
    step(2);
    chk(out_addr == 32'hA1, "R1 order 1", out_addr, 32'hA1);
    pulse_ready();
    chk(out_addr == 32'hB2, "R1 order 2", out_addr, 32'hB2);
    pulse_ready();
    chk(out_addr == 32'hC3, "R1 order 3", out_addr, 32'hC3);
    pulse_ready();
    chk(out_valid == 1'b0, "R1 drained", out_valid, 0);

    // R1 full queue
    apply_reset();
    for (int k = 0; k <= DEPTH; k++) push(2'd2, AW'(k));
    pf_bank = 2'd2;
    step(1);
    chk(pf_ready == 1'b0, "R1 full bank", pf_ready, 0);
    pf_bank = 2'd0;
    step(1);
    chk(pf_ready == 1'b1, "R1 other bank", pf_ready, 1);
    pulse_ready();
    pf_bank = 2'd2;
    step(1);
    chk(pf_ready == 1'b1, "R1 room after pop", pf_ready, 1);

    // R2 floor and same-cycle pair, then increment
    apply_reset();
    bump(1, 1'b0, 1'b1, 3);
    bump(1, 1'b1, 1'b1, 5);
    bump(1, 1'b1, 1'b0, 1);
    push(2'd1, 32'h0000_0111);
    step(3);
    chk(out_valid && out_bank == 2'd1, "R2 count one eligible", out_valid, 1);
    pulse_ready();
    chk(out_valid == 1'b0, "R2 drain", out_valid, 0);
    bump(1, 1'b1, 1'b0, 1);
    push(2'd1, 32'h0000_0222);
    step(3);
    chk(out_valid == 1'b0, "R2 count two blocked", out_valid, 0);

    // R2 ceiling
    apply_reset();
    bump(0, 1'b1, 1'b0, 40);
    bump(0, 1'b0, 1'b1, 31);
    push(2'd0, 32'h0000_0333);
    step(3);
    chk(out_valid && out_addr == 32'h333, "R2 saturate high", out_addr, 32'h333);

    // R6 empty interval keeps level, counters clear at interval end
    apply_reset();
    set_level(8);
    wait_until(140);
    bump(0, 1'b1, 1'b0, 5);
    push(2'd0, 32'h0000_0444);
    step(3);
    chk(out_valid && out_addr == 32'h444, "R6 level kept", out_addr, 32'h444);
    pulse_ready();
    wait_until(195);
    set_level(20);
    wait_until(260);
    bump(0, 1'b1, 1'b0, 15);
    push(2'd0, 32'h0000_0555);
    step(3);
    chk(out_valid && out_addr == 32'h555, "R6 counts cleared", out_addr, 32'h555);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule